// File: doc/BRIEF.md
# Column Partial-Sum Accumulator with Fused Max-Pool

This block closes a column of four processing clusters in an in-memory convolution engine. Each cluster delivers one word per kernel lane, four lanes in all, along with its own valid bit. In every cycle in which at least one cluster is valid, the block adds the valid clusters' words lane by lane into four accumulators. A pixel whose dot product needs more multiply-accumulates than one pass of the clusters can supply is built over several such beats. The per-layer configuration sets how many beats make up one pixel.

A pooling stage follows the accumulators. It keeps a running unsigned maximum per lane over a configured number of finished pixels. When a pooling window completes, it writes the four pooled values out with a one-cycle strobe. A window size of one passes every finished pixel straight through. The configuration is loaded with a single strobe. Loading it also discards any partial pixel and any partial window.

Top module: `col_accpool`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_wr` is 0 and every lane of `out_pix` is 0. Reset also selects one beat per pixel and a pooling window of one.
- R2: A beat is a cycle in which `cfg_load` is low and any bit of `clu_valid` is high. In a beat, lane l adds exactly the words of the clusters whose valid bit is set. The word of cluster c, lane l sits at bits [(c*4+l)*12 +: 12] of `clu_word`.
- R3: A pixel completes on the beat that brings the beat count to the configured `cfg_beats`. Cycles with no valid cluster neither count nor disturb the partial sum. After completion, accumulation restarts from zero.
- R4: A `cfg_beats` value of 0 is treated as 1.
- R5: With a pooling window of 1, every completed pixel is written out unchanged.
- R6: With a pooling window W greater than 1, one write occurs per W completed pixels. Each lane carries the unsigned maximum of its own W pixel values, independent of the other lanes.
- R7: `out_wr` is high for the one cycle after the clock edge that ends the completing beat. `out_pix` changes only together with `out_wr` and holds its value otherwise. Lane l of `out_pix` is bits [l*18 +: 18].
- R8: A cycle with `cfg_load` high captures the new configuration, clears the partial sum and the window position, and ignores any cluster data presented in that cycle. No write follows it.
- R9: A `cfg_pool` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture configuration and restart pixel and window |
| cfg_beats | input | 4 | Beats per pixel (0 means 1) |
| cfg_pool | input | 3 | Pooling window in pixels (0 or 1 means bypass) |
| clu_valid | input | 4 | Per-cluster valid bits |
| clu_word | input | 192 | Four clusters by four lanes of 12-bit partial sums |
| out_wr | output | 1 | Write strobe for the output buffer |
| out_pix | output | 72 | Four 18-bit pooled pixel values |

## Verification
Every result appears one clock edge after the beat that causes it. The strobe and the pooled values are registered together, so there is no further latency to account for. The bench changes inputs on the falling edge, lets one rising edge pass, and then samples `out_wr` and all four lanes on the next falling edge. It compares them with a reference model that it advances once per driven cycle. Idle cycles and load cycles are stepped the same way, so the bench confirms that no write appears and that `out_pix` holds its value.

// File: rtl/colacc_pkg.sv
package colacc_pkg;

    localparam int DEF_N_CLU  = 4;
    localparam int DEF_N_LANE = 4;
    localparam int DEF_WORD_W = 12;
    localparam int DEF_CNT_W  = 4;
    localparam int DEF_POOL_W = 3;

    // Control bundle from the sequencer to every lane.
    typedef struct packed {
        logic clr;
        logic beat;
        logic pix_done;
        logic win_first;
        logic win_last;
    } lane_ctl_t;

    function automatic int acc_width(int word_w, int n_clu, int cnt_w);
        return word_w + $clog2(n_clu) + cnt_w;
    endfunction

endpackage

// File: rtl/col_merge.sv
module col_merge
    import colacc_pkg::*;
#(
    parameter int N_CLU  = DEF_N_CLU,
    parameter int WORD_W = DEF_WORD_W,
    parameter int SUM_W  = WORD_W + $clog2(N_CLU)
) (
    input  logic [N_CLU-1:0]        valid,
    input  logic [N_CLU*WORD_W-1:0] words,
    output logic [SUM_W-1:0]        sum
);

    always_comb begin
        sum = '0;
        for (int c = 0; c < N_CLU; c++) begin
            if (valid[c]) begin
                sum = sum + SUM_W'(words[c*WORD_W +: WORD_W]);
            end
        end
    end

endmodule

// File: rtl/col_seq.sv
module col_seq
    import colacc_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int POOL_W = DEF_POOL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  beats_in,
    input  logic [POOL_W-1:0] pool_in,
    input  logic              any_valid,
    output lane_ctl_t         ctl,
    output logic              wr
);

    logic [CNT_W-1:0]  beats_q;
    logic [POOL_W-1:0] pool_q;
    logic [CNT_W-1:0]  bcnt_q;
    logic [POOL_W-1:0] wcnt_q;

    always_comb begin
        ctl.clr       = load;
        ctl.beat      = any_valid & ~load;
        ctl.pix_done  = ctl.beat && (bcnt_q == beats_q - CNT_W'(1));
        ctl.win_first = (wcnt_q == '0);
        ctl.win_last  = (wcnt_q == pool_q - POOL_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= CNT_W'(1);
            pool_q  <= POOL_W'(1);
            bcnt_q  <= '0;
            wcnt_q  <= '0;
            wr      <= 1'b0;
        end else begin
            wr <= ctl.pix_done & ctl.win_last;
            if (load) begin
                beats_q <= (beats_in == '0) ? CNT_W'(1) : beats_in;
                pool_q  <= (pool_in == '0) ? POOL_W'(1) : pool_in;
                bcnt_q  <= '0;
                wcnt_q  <= '0;
            end else if (ctl.beat) begin
                if (ctl.pix_done) begin
                    bcnt_q <= '0;
                    wcnt_q <= ctl.win_last ? '0 : wcnt_q + POOL_W'(1);
                end else begin
                    bcnt_q <= bcnt_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pool_lane.sv
module pool_lane
    import colacc_pkg::*;
#(
    parameter int SUM_W = DEF_WORD_W + 2,
    parameter int ACC_W = SUM_W + DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  lane_ctl_t        ctl,
    input  logic [SUM_W-1:0] add,
    output logic [ACC_W-1:0] pix
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] max_q;
    logic [ACC_W-1:0] total;
    logic [ACC_W-1:0] cand;

    always_comb begin
        total = acc_q + ACC_W'(add);
        if (ctl.win_first || total > max_q) begin
            cand = total;
        end else begin
            cand = max_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            max_q <= '0;
            pix   <= '0;
        end else if (ctl.clr) begin
            acc_q <= '0;
        end else if (ctl.beat) begin
            if (ctl.pix_done) begin
                acc_q <= '0;
                max_q <= cand;
                if (ctl.win_last) begin
                    pix <= cand;
                end
            end else begin
                acc_q <= total;
            end
        end
    end

endmodule

// File: rtl/col_accpool.sv
module col_accpool
    import colacc_pkg::*;
#(
    parameter int N_CLU  = DEF_N_CLU,
    parameter int N_LANE = DEF_N_LANE,
    parameter int WORD_W = DEF_WORD_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int POOL_W = DEF_POOL_W,
    localparam int SUM_W = WORD_W + $clog2(N_CLU),
    localparam int ACC_W = acc_width(WORD_W, N_CLU, CNT_W)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cfg_load,
    input  logic [CNT_W-1:0]                 cfg_beats,
    input  logic [POOL_W-1:0]                cfg_pool,
    input  logic [N_CLU-1:0]                 clu_valid,
    input  logic [N_CLU*N_LANE*WORD_W-1:0]   clu_word,
    output logic                             out_wr,
    output logic [N_LANE*ACC_W-1:0]          out_pix
);

    lane_ctl_t ctl;

    col_seq #(
        .CNT_W (CNT_W),
        .POOL_W(POOL_W)
    ) i_seq (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .beats_in (cfg_beats),
        .pool_in  (cfg_pool),
        .any_valid(|clu_valid),
        .ctl      (ctl),
        .wr       (out_wr)
    );

    for (genvar l = 0; l < N_LANE; l++) begin : g_lane
        logic [N_CLU*WORD_W-1:0] lane_words;
        logic [SUM_W-1:0]        lane_sum;

        always_comb begin
            for (int c = 0; c < N_CLU; c++) begin
                lane_words[c*WORD_W +: WORD_W] = clu_word[(c*N_LANE+l)*WORD_W +: WORD_W];
            end
        end

        col_merge #(
            .N_CLU (N_CLU),
            .WORD_W(WORD_W),
            .SUM_W (SUM_W)
        ) i_merge (
            .valid(clu_valid),
            .words(lane_words),
            .sum  (lane_sum)
        );

        pool_lane #(
            .SUM_W(SUM_W),
            .ACC_W(ACC_W)
        ) i_pool (
            .clk(clk),
            .rst(rst),
            .ctl(ctl),
            .add(lane_sum),
            .pix(out_pix[l*ACC_W +: ACC_W])
        );
    end

endmodule

// File: rtl/col_accpool_chk.sv
module col_accpool_chk #(
    parameter int N_CLU = 4,
    parameter int PIX_W = 72
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [N_CLU-1:0] clu_valid,
    input logic             out_wr,
    input logic [PIX_W-1:0] out_pix
);

    // R1: outputs are quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!out_wr && out_pix == '0));

    // R8: a load cycle is never followed by a write
    a_r8_load_no_write: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> !out_wr);

    // R3: a cycle without any valid cluster cannot produce a write
    a_r3_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        (clu_valid == '0) |=> !out_wr);

    // R7: pixel values only move together with the strobe
    a_r7_hold_pix: assert property (@(posedge clk) disable iff (rst)
        !out_wr |-> $stable(out_pix));

endmodule

bind col_accpool col_accpool_chk #(
    .N_CLU(N_CLU),
    .PIX_W(N_LANE*ACC_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .clu_valid(clu_valid),
    .out_wr   (out_wr),
    .out_pix  (out_pix)
);

// File: tb/test_col_accpool.sv
module test_col_accpool;

    localparam int NC = 4, NL = 4, WW = 12, AW = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic [3:0]        cfg_beats = '0;
    logic [2:0]        cfg_pool = '0;
    logic [NC-1:0]     clu_valid = '0;
    logic [NC*NL*WW-1:0] clu_word = '0;
    logic              out_wr;
    logic [NL*AW-1:0]  out_pix;

    int n_checks = 0;
    int n_errors = 0;

    // model state
    int m_beats = 1, m_pool = 1, m_bc = 0, m_wc = 0;
    int m_acc[NL];
    int m_max[NL];
    int e_pix[NL];
    bit e_wr = 0;

    always #4 clk = ~clk;

    col_accpool i_col_accpool (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_beats(cfg_beats),
        .cfg_pool(cfg_pool), .clu_valid(clu_valid), .clu_word(clu_word),
        .out_wr(out_wr), .out_pix(out_pix)
    );

    // {load, beats[3:0], pool[2:0], mask[3:0], seed[7:0]}
    localparam logic [19:0] VEC [18] = '{
        {1'b1, 4'd1, 3'd1, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd1},
        {1'b0, 4'd0, 3'd0, 4'h5, 8'd2},
        {1'b1, 4'd3, 3'd1, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd3},
        {1'b0, 4'd0, 3'd0, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hA, 8'd4},
        {1'b0, 4'd0, 3'd0, 4'h1, 8'd5},
        {1'b1, 4'd2, 3'd2, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd6},
        {1'b0, 4'd0, 3'd0, 4'h3, 8'd7},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd200},
        {1'b0, 4'd0, 3'd0, 4'hC, 8'd9},
        {1'b1, 4'd1, 3'd3, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd10},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd250},
        {1'b0, 4'd0, 3'd0, 4'h0, 8'd0},
        {1'b0, 4'd0, 3'd0, 4'hF, 8'd11}
    };

    function automatic int wgen(int seed, int c, int l);
        return (seed * 37 + c * 101 + l * 53 + (seed >= 200 ? 3900 : 0)) % 4096;
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    task automatic check(string tag);
        n_checks++;
        if (out_wr !== e_wr) begin
            n_errors++;
            $display("FAIL %s: out_wr=%0b expected %0b", tag, out_wr, e_wr);
        end
        for (int l = 0; l < NL; l++) begin
            if (out_pix[l*AW +: AW] !== AW'(e_pix[l])) begin
                n_errors++;
                $display("FAIL %s: lane %0d pix=%0d expected %0d",
                         tag, l, out_pix[l*AW +: AW], e_pix[l]);
            end
        end
    endtask

    // drive one cycle, advance model, sample one edge later
    task automatic step(bit ld, int beats, int pool, logic [3:0] mask, int seed, string tag);
        bit done, last;
        int tot, cand;
        cfg_load  = ld;
        cfg_beats = 4'(beats);
        cfg_pool  = 3'(pool);
        clu_valid = mask;
        for (int c = 0; c < NC; c++)
            for (int l = 0; l < NL; l++)
                clu_word[(c*NL+l)*WW +: WW] = WW'(wgen(seed, c, l));
        e_wr = 0;
        if (ld) begin
            m_beats = (beats == 0) ? 1 : beats;
            m_pool  = (pool == 0) ? 1 : pool;
            m_bc = 0; m_wc = 0;
            for (int l = 0; l < NL; l++) m_acc[l] = 0;
        end else if (mask != 0) begin
            done = (m_bc == m_beats - 1);
            last = (m_wc == m_pool - 1);
            for (int l = 0; l < NL; l++) begin
                tot = m_acc[l];
                for (int c = 0; c < NC; c++)
                    if (mask[c]) tot += wgen(seed, c, l);
                if (done) begin
                    cand = (m_wc == 0 || tot > m_max[l]) ? tot : m_max[l];
                    m_max[l] = cand;
                    m_acc[l] = 0;
                    if (last) e_pix[l] = cand;
                end else begin
                    m_acc[l] = tot;
                end
            end
            if (done) begin
                e_wr = last;
                m_bc = 0;
                m_wc = last ? 0 : m_wc + 1;
            end else begin
                m_bc++;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        #(8 * 5000);
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            m_acc[l] = 0; m_max[l] = 0; e_pix[l] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1");

        // table walk
        for (int i = 0; i < 18; i++) begin
            string tag;
            logic [19:0] v;
            v = VEC[i];
            if (v[19]) tag = "R8";
            else if (v[11:8] == 4'h0) tag = "R3";
            else if (m_pool > 1) tag = "R6";
            else if (m_beats > 1) tag = "R3";
            else tag = "R5";
            step(v[19], int'(v[18:15]), int'(v[14:12]), v[11:8], int'(v[7:0]), tag);
        end

        // R2: only selected clusters contribute
        step(1, 1, 1, 4'h0, 0, "R8");
        step(0, 0, 0, 4'b0110, 30, "R2");
        step(0, 0, 0, 4'b1000, 31, "R2");

        // R4: zero beats behaves as one
        step(1, 0, 1, 4'h0, 0, "R8");
        step(0, 0, 0, 4'hF, 40, "R4");

        // R9: zero pool behaves as bypass
        step(1, 1, 0, 4'h0, 0, "R8");
        step(0, 0, 0, 4'hF, 41, "R9");

        // R7: output holds through idle cycles
        step(0, 0, 0, 4'h0, 42, "R7");
        step(0, 0, 0, 4'h0, 43, "R7");

        // R8: load mid-pixel discards partial sum and its own data
        step(1, 2, 1, 4'h0, 0, "R8");
        step(0, 0, 0, 4'hF, 20, "R8");
        step(1, 2, 1, 4'hF, 21, "R8");
        step(0, 0, 0, 4'hF, 22, "R8");
        step(0, 0, 0, 4'hF, 23, "R8");

        // R6: max across window with lanes mixing large and small
        step(1, 1, 2, 4'h0, 0, "R8");
        step(0, 0, 0, 4'hF, 210, "R6");
        step(0, 0, 0, 4'h1, 12, "R6");

        finish_run();
    end

endmodule